// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one data channel of a parallel peripheral port, run in strobed handshake mode. Its direction is chosen at run time. As an input channel, the peripheral pulses an active-low strobe. The channel captures the data pins into a holding latch and raises a buffer-full flag. The CPU then reads the latch, and that read clears the flag. As an output channel, a CPU write places data on the pins and drives an active-low buffer-full line. The peripheral answers with an active-low acknowledge, which releases that line. In both directions an interrupt request tells the CPU that the channel wants service. The request is gated by an enable flag.

The handshake lines sit on fixed bits of a shared 8-bit control port. The parameter `GROUP_HI` chooses which set of bits the channel owns, either the upper group or the lower group. The CPU sees three things. First, single-cycle-synchronous read and write levels for this channel, each already decoded by the control core. Second, a bit set/reset command, which is the only way to reach the interrupt enable. Third, a status word that merges the handshake state with the levels of the control-port pins that the channel does not use. The strobe and acknowledge inputs, and the data pins that go with them, pass through a synchroniser of `SYNC_STAGES` flops before they are used.

Top module: `hs_port_chan`

## Requirements
- R1: After reset the input buffer-full flag is 0, the active-low output buffer-full line is 1, the interrupt enable is 0, `irq` is 0, `pin_oe` is 0 and `pin_out` is 0.
- R2: In input mode (`dir_out`=0), a low level on the strobe pin loads `pin_in` into the input latch and sets buffer-full. Both take effect at the third rising clock edge after the pin goes low. While in input mode, `cpu_rdata` returns the latch, and the latch keeps its value after the strobe returns high, even if `pin_in` then changes.
- R3: The input buffer-full flag stays 1 while `cpu_rd` is high. It is cleared at the clock edge where `cpu_rd` is first seen low again, which is the end of the read.
- R4: In input mode, `irq` rises at the third clock edge after the strobe pin returns high, provided buffer-full and the enable are both 1. It is cleared at the first clock edge that sees `cpu_rd` high.
- R5: In output mode (`dir_out`=1), `pin_oe` is 1 and `pin_out` follows `cpu_wdata` from the first edge of a write. The active-low output buffer-full line goes low at the clock edge where `cpu_wr` is first seen low again.
- R6: The output buffer-full line returns high at the third clock edge after the acknowledge pin goes low.
- R7: In output mode, `irq` is 1 whenever the synchronised acknowledge is high, the buffer-full line is high and the enable is 1. It rises at the third edge after the acknowledge pin returns high, or at the edge after the enable is set. It is cleared at the first edge that sees `cpu_wr` high.
- R8: `irq` is never 1 unless the enable was 1 at the previous edge. Clearing the enable drops `irq` one edge after the enable falls.
- R9: A set/reset command (`bsr_valid`, `bsr_bit`, `bsr_val`) loads the enable only when `bsr_bit` addresses the enable position: bit 4 in input mode and bit 6 in output mode for the upper group, and bit 2 for the lower group. Commands to any other bit have no visible effect.
- R10: The channel drives exactly two control-port bits. The buffer-full bit is driven on bit 5 (input) or bit 7 (output) for the upper group, and on bit 1 for the lower group. The interrupt bit is driven on bit 3 for the upper group and on bit 0 for the lower group. `pc_oe` is 1 on exactly those bits, and `pc_out` is 0 elsewhere.
- R11: `pc_status` contains the enable at the strobe/acknowledge position (bit 4 or 6 for upper, bit 2 for lower), buffer-full at the R10 buffer-full bit and `irq` at the R10 interrupt bit. The remaining bits are copied from `pc_in`.
- R12: A change of `dir_out` takes effect at the next edge. At that edge the input buffer-full flag, `irq` and the enable are cleared, the output buffer-full line is set high, and the output latch is set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 selects output mode, 0 selects input mode |
| cpu_rd | input | 1 | CPU read level for this channel |
| cpu_wr | input | 1 | CPU write level for this channel |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Input latch (input mode) or output latch (output mode) |
| bsr_valid | input | 1 | Bit set/reset command strobe |
| bsr_bit | input | 3 | Control-port bit addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| pin_in | input | DW | Data pins as seen from outside |
| pin_out | output | DW | Data pin drive value |
| pin_oe | output | 1 | Data pin drive enable |
| pc_in | input | 8 | Control-port pin levels |
| pc_out | output | 8 | Control-port drive values for owned bits |
| pc_oe | output | 8 | Control-port drive enables |
| pc_status | output | 8 | Status word for a control-port read |
| irq | output | 1 | Interrupt request |

## Verification
Pin-driven events pass through two synchroniser flops and one state register, so their result appears at the third rising edge after the pin changes. CPU read and write edges, and set/reset commands, act at the first edge. An interrupt that depends on a just-updated enable appears one edge after that. The bench changes inputs just after a falling edge and samples at the following falling edges. For each pin event it checks the expected outputs twice: once after the second rising edge, where the old state must still be present, and again after the third, where the new state must be present. For the one-edge paths it checks directly after that edge. This pins down every latency exactly, and a result that comes a cycle early or late fails.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
   localparam int PC_W = 8;

   typedef logic [2:0] pc_pos_t;

   typedef struct packed {
      pc_pos_t hs;   // strobe / acknowledge input, also enable command bit
      pc_pos_t bf;   // buffer-full output
      pc_pos_t irq;  // interrupt output
   } pc_map_t;

   function automatic pc_map_t pc_map_f(input bit hi_grp, input bit out_mode);
      pc_map_t m;
      if (hi_grp) begin
         m.irq = 3'd3;
         m.hs  = out_mode ? 3'd6 : 3'd4;
         m.bf  = out_mode ? 3'd7 : 3'd5;
      end else begin
         m.irq = 3'd0;
         m.hs  = 3'd2;
         m.bf  = 3'd1;
      end
      return m;
   endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

   initial begin : prm_chk
      assert (STAGES >= 2 && W >= 1) else $error("hs_sync: STAGES must be >= 2");
   end
endmodule

// File: rtl/hs_bus_edge.sv
module hs_bus_edge #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] lvl_q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/hs_in_side.sv
module hs_in_side #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          clr,
   input  logic          inte,
   input  logic          stb_s,
   input  logic [DW-1:0] pin_s,
   input  logic          rd_start,
   input  logic          rd_end,
   input  logic          rd_busy,
   output logic          ibf,
   output logic          irq,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf  <= 1'b0;
         irq  <= 1'b0;
         data <= '0;
      end else if (clr || !active) begin
         ibf <= 1'b0;
         irq <= 1'b0;
      end else begin
         if (!stb_s) begin
            data <= pin_s;
            ibf  <= 1'b1;
         end else if (rd_end) begin
            ibf <= 1'b0;
         end
         if (stb_s && ibf && inte && !rd_busy) irq <= 1'b1;
         else if (rd_start || !inte)           irq <= 1'b0;
      end
   end

   // R2
   ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |-> $past(!stb_s && active));

   // R4
   irq_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rd_start) |=> !irq);
endmodule

// File: rtl/hs_out_side.sv
module hs_out_side #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          clr,
   input  logic          inte,
   input  logic          ack_s,
   input  logic          wr_lvl,
   input  logic [DW-1:0] wdata,
   input  logic          wr_start,
   input  logic          wr_end,
   input  logic          wr_busy,
   output logic          obf_n,
   output logic          irq,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obf_n <= 1'b1;
         irq   <= 1'b0;
         data  <= '0;
      end else if (clr) begin
         obf_n <= 1'b1;
         irq   <= 1'b0;
         data  <= '0;
      end else if (!active) begin
         obf_n <= 1'b1;
         irq   <= 1'b0;
      end else begin
         if (wr_lvl) data <= wdata;
         if (wr_end)      obf_n <= 1'b0;
         else if (!ack_s) obf_n <= 1'b1;
         if (ack_s && obf_n && inte && !wr_busy) irq <= 1'b1;
         else if (wr_start || !inte)            irq <= 1'b0;
      end
   end

   // R5
   obf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(obf_n) |-> $past(wr_end));

   // R6
   obf_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(obf_n) |-> $past(!ack_s || clr || !active));

   // R7
   irq_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && wr_start) |=> !irq);
endmodule

// File: rtl/hs_port_chan.sv
module hs_port_chan
   import hs_port_pkg::*;
#(
   parameter int DW          = 8,
   parameter bit GROUP_HI    = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_out,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   input  logic          bsr_valid,
   input  logic [2:0]    bsr_bit,
   input  logic          bsr_val,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] pin_out,
   output logic          pin_oe,
   input  logic [7:0]    pc_in,
   output logic [7:0]    pc_out,
   output logic [7:0]    pc_oe,
   output logic [7:0]    pc_status,
   output logic          irq
);
   localparam pc_map_t MAP_I = pc_map_f(GROUP_HI, 1'b0);
   localparam pc_map_t MAP_O = pc_map_f(GROUP_HI, 1'b1);
   localparam logic [DW:0] SYNC_RST = {1'b1, {DW{1'b0}}};

   initial begin : prm_chk
      assert (DW >= 1 && SYNC_STAGES >= 2 && PC_W == 8)
         else $error("hs_port_chan: bad parameters");
   end

   pc_map_t map_c;
   assign map_c = dir_out ? MAP_O : MAP_I;

   // direction change detection
   logic dir_q, mode_chg;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= 1'b0;
      else        dir_q <= dir_out;
   end
   assign mode_chg = (dir_out != dir_q);

   // handshake line and data pins synchronised together
   logic          hs_s;
   logic [DW-1:0] pin_s;
   hs_sync #(.W(DW+1), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({pc_in[map_c.hs], pin_in}),
      .q({hs_s, pin_s})
   );

   // CPU strobe edges: bit 0 read, bit 1 write
   logic [1:0] bus_q, bus_rise, bus_fall;
   hs_bus_edge #(.W(2)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .lvl({cpu_wr, cpu_rd}),
      .lvl_q(bus_q), .rise(bus_rise), .fall(bus_fall)
   );

   // interrupt enable, reached only through the set/reset command
   logic inte_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  inte_q <= 1'b0;
      else if (mode_chg)                           inte_q <= 1'b0;
      else if (bsr_valid && bsr_bit == map_c.hs)   inte_q <= bsr_val;
   end

   logic          ibf, irq_in, obf_n, irq_out;
   logic [DW-1:0] in_data, out_data;

   hs_in_side #(.DW(DW)) u_in (
      .clk(clk), .rst_n(rst_n),
      .active(!dir_out), .clr(mode_chg), .inte(inte_q),
      .stb_s(hs_s), .pin_s(pin_s),
      .rd_start(bus_rise[0]), .rd_end(bus_fall[0]),
      .rd_busy(cpu_rd | bus_q[0]),
      .ibf(ibf), .irq(irq_in), .data(in_data)
   );

   hs_out_side #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .active(dir_out), .clr(mode_chg), .inte(inte_q),
      .ack_s(hs_s), .wr_lvl(cpu_wr), .wdata(cpu_wdata),
      .wr_start(bus_rise[1]), .wr_end(bus_fall[1]),
      .wr_busy(cpu_wr | bus_q[1]),
      .obf_n(obf_n), .irq(irq_out), .data(out_data)
   );

   logic bf;
   assign bf        = dir_out ? obf_n   : ibf;
   assign irq       = dir_out ? irq_out : irq_in;
   assign cpu_rdata = dir_out ? out_data : in_data;
   assign pin_out   = out_data;
   assign pin_oe    = dir_out;

   // control-port bit multiplexing and status word
   for (genvar b = 0; b < PC_W; b++) begin : g_pc
      localparam pc_pos_t POS = pc_pos_t'(b);
      assign pc_oe[b]     = (map_c.bf == POS) || (map_c.irq == POS);
      assign pc_out[b]    = (map_c.bf == POS)  ? bf  :
                            (map_c.irq == POS) ? irq : 1'b0;
      assign pc_status[b] = (map_c.hs == POS)  ? inte_q :
                            (map_c.bf == POS)  ? bf     :
                            (map_c.irq == POS) ? irq    : pc_in[b];
   end

   // R8
   irq_inte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(inte_q));

   // R9
   inte_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inte_q) |-> $past(bsr_valid && bsr_val));

   // R12
   mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir_out != $past(dir_out)) && $past(rst_n))
         |=> (!ibf && obf_n && !inte_q && !irq && out_data == '0));
endmodule

// File: tb/hs_port_chan_tb.sv
`timescale 1ns/1ps
module hs_port_chan_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, dir_out, cpu_rd, cpu_wr, bsr_valid, bsr_val, hs_n;
   logic [7:0] cpu_wdata, pin_in, pc_bg;
   logic [2:0] bsr_bit_a, bsr_bit_b;
   logic [7:0] pcin_a, pcin_b;
   logic [7:0] rdata_a, rdata_b, pout_a, pout_b;
   logic [7:0] pcout_a, pcout_b, pcoe_a, pcoe_b, stat_a, stat_b;
   logic       oe_a, oe_b, irq_a, irq_b;

   assign pcin_a = {pc_bg[7], hs_n, pc_bg[5], hs_n, pc_bg[3:0]};
   assign pcin_b = {pc_bg[7:3], hs_n, pc_bg[1:0]};

   hs_port_chan #(.DW(8), .GROUP_HI(1'b1), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_a), .bsr_valid(bsr_valid),
      .bsr_bit(bsr_bit_a), .bsr_val(bsr_val), .pin_in(pin_in), .pin_out(pout_a),
      .pin_oe(oe_a), .pc_in(pcin_a), .pc_out(pcout_a), .pc_oe(pcoe_a),
      .pc_status(stat_a), .irq(irq_a));

   hs_port_chan #(.DW(8), .GROUP_HI(1'b0), .SYNC_STAGES(2)) u_dut_lo (
      .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_b), .bsr_valid(bsr_valid),
      .bsr_bit(bsr_bit_b), .bsr_val(bsr_val), .pin_in(pin_in), .pin_out(pout_b),
      .pin_oe(oe_b), .pc_in(pcin_b), .pc_out(pcout_b), .pc_oe(pcoe_b),
      .pc_status(stat_b), .irq(irq_b));

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;
   // bench model of the channel state
   bit  e_ibf = 0, e_obfn = 1, e_inte = 0, e_irq = 0;
   logic [7:0] e_din = '0, e_dout = '0;

   function automatic int pos_hs(bit hi);  return hi ? (dir_out ? 6 : 4) : 2; endfunction
   function automatic int pos_bf(bit hi);  return hi ? (dir_out ? 7 : 5) : 1; endfunction
   function automatic int pos_irq(bit hi); return hi ? 3 : 0; endfunction

   function automatic logic [7:0] exp_stat(bit hi, logic [7:0] pcin);
      logic [7:0] s = pcin;
      s[pos_hs(hi)]  = e_inte;
      s[pos_bf(hi)]  = dir_out ? e_obfn : e_ibf;
      s[pos_irq(hi)] = e_irq;
      return s;
   endfunction

   function automatic logic [7:0] exp_oe(bit hi);
      logic [7:0] s = '0;
      s[pos_bf(hi)] = 1'b1; s[pos_irq(hi)] = 1'b1;
      return s;
   endfunction

   function automatic logic [7:0] exp_out(bit hi);
      logic [7:0] s = '0;
      s[pos_bf(hi)]  = dir_out ? e_obfn : e_ibf;
      s[pos_irq(hi)] = e_irq;
      return s;
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      logic [7:0] rd_exp = dir_out ? e_dout : e_din;
      chk(req,   "irq_hi",   {7'd0, irq_a}, {7'd0, e_irq});
      chk(req,   "irq_lo",   {7'd0, irq_b}, {7'd0, e_irq});
      chk("R11", "stat_hi",  stat_a, exp_stat(1'b1, pcin_a));
      chk("R11", "stat_lo",  stat_b, exp_stat(1'b0, pcin_b));
      chk("R10", "pcoe_hi",  pcoe_a, exp_oe(1'b1));
      chk("R10", "pcoe_lo",  pcoe_b, exp_oe(1'b0));
      chk("R10", "pcout_hi", pcout_a, exp_out(1'b1));
      chk("R10", "pcout_lo", pcout_b, exp_out(1'b0));
      chk(req,   "rdata_hi", rdata_a, rd_exp);
      chk(req,   "rdata_lo", rdata_b, rd_exp);
      chk(req,   "pin_oe",   {6'd0, oe_a, oe_b}, {6'd0, dir_out, dir_out});
      if (dir_out) begin
         chk(req, "pin_out_hi", pout_a, e_dout);
         chk(req, "pin_out_lo", pout_b, e_dout);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R12: direction change
   task automatic set_dir(input bit d);
      if (d != dir_out) begin
         dir_out = d;
         step(1);
         e_ibf = 0; e_obfn = 1; e_inte = 0; e_irq = 0; e_dout = '0;
         check_all("R12");
         step(2);
      end
   endtask

   // R9 / R8: enable set/reset through the command
   task automatic set_inte(input bit en);
      bsr_valid = 1'b1; bsr_val = en;
      bsr_bit_a = 3'(pos_hs(1'b1)); bsr_bit_b = 3'(pos_hs(1'b0));
      step(1);
      bsr_valid = 1'b0;
      e_inte = en;
      check_all("R9");
      step(1);
      e_irq = dir_out ? (en & e_obfn) : (en & (e_irq | e_ibf));
      check_all("R8");
   endtask

   // R9: commands to other bits are ignored
   task automatic bsr_noise();
      logic [2:0] a = 3'($urandom % 8);
      logic [2:0] b = 3'($urandom % 8);
      if (int'(a) == pos_hs(1'b1)) a = a ^ 3'd1;
      if (int'(b) == pos_hs(1'b0)) b = b ^ 3'd1;
      bsr_valid = 1'b1; bsr_val = 1'($urandom % 2);
      bsr_bit_a = a; bsr_bit_b = b;
      step(1);
      bsr_valid = 1'b0;
      step(1);
      check_all("R9");
   endtask

   task automatic in_xfer(input logic [7:0] data, input bit en, input bit dis_mid);
      set_inte(en);
      bsr_noise();
      pin_in = data; hs_n = 1'b0;
      step(2); check_all("R2");
      step(1); e_ibf = 1; e_din = data; check_all("R2");
      step(1); hs_n = 1'b1;
      step(2); check_all("R4");
      step(1); e_irq = e_inte; check_all("R4");
      pin_in = ~data;
      step(3); check_all("R2");
      if (dis_mid && e_inte) set_inte(1'b0);
      cpu_rd = 1'b1;
      step(1); e_irq = 0; check_all("R4");
      step(1); check_all("R3");
      cpu_rd = 1'b0;
      step(1); e_ibf = 0; check_all("R3");
      step(1);
   endtask

   task automatic out_xfer(input logic [7:0] data, input bit en);
      set_inte(en);
      bsr_noise();
      cpu_wr = 1'b1; cpu_wdata = data;
      step(1); e_irq = 0; e_dout = data; check_all("R7");
      step(1); check_all("R5");
      cpu_wr = 1'b0;
      step(1); e_obfn = 0; check_all("R5");
      hs_n = 1'b0;
      step(2); check_all("R6");
      step(1); e_obfn = 1; check_all("R6");
      step(1); hs_n = 1'b1;
      step(2); check_all("R7");
      step(1); e_irq = e_inte; check_all("R7");
      step(1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = $urandom(32'd2024);
      rst_n = 1'b0; dir_out = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
      bsr_valid = 1'b0; bsr_val = 1'b0; bsr_bit_a = '0; bsr_bit_b = '0;
      pin_in = 8'h5A; pc_bg = 8'h96; hs_n = 1'b1;
      step(4);
      rst_n = 1'b1;
      step(1);
      check_all("R1");
      chk("R1", "pin_out_rst", pout_a, 8'h00);

      // directed corners
      set_dir(1'b1);
      out_xfer(8'hA5, 1'b1);
      out_xfer(8'h00, 1'b0);
      set_dir(1'b0);
      in_xfer(8'h3C, 1'b1, 1'b1);
      in_xfer(8'hFF, 1'b0, 1'b0);
      // R12: switch direction with a pending input and interrupt
      set_inte(1'b1);
      pin_in = 8'hC3; hs_n = 1'b0;
      step(3); e_ibf = 1; e_din = 8'hC3; check_all("R2");
      hs_n = 1'b1;
      step(3); e_irq = 1; check_all("R4");
      set_dir(1'b1);
      set_dir(1'b0);

      // constrained random transactions
      for (int i = 0; i < 40; i++) begin
         bit d;
         pc_bg = 8'($urandom);
         d = 1'($urandom % 2);
         set_dir(d);
         if (d) out_xfer(8'($urandom), 1'($urandom % 2));
         else   in_xfer(8'($urandom), 1'($urandom % 2), 1'($urandom % 2));
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule